// File: doc/BRIEF.md
# I2C Master SCL Bit-Rate Generator

This block derives the serial clock of an I2C master from the system clock. A 3-bit rate code picks one of seven fixed divide ratios or a variable ratio set by an 8-bit timer reload value. Each full SCL period splits into a low half and a high half. The block drives the SCL line open-drain style: `scl_out` low pulls the line down, and high releases it. The block reads the wire back on `scl_in`. The high half is not counted until the line is seen high, so a slave that holds SCL low stretches the clock. A one-cycle pulse marks each rising edge and each falling edge, for the shift logic of the master engine.

The rate code and reload value are captured only while the master engine reports an idle bus. A change made during a transfer therefore waits for the next idle period. While master mode is off, the line stays released and no pulses appear. All pins are plain control or status levels. No data stream passes through this block, so it has no valid/ready handshake.

Top module: `scl_rate_gen`

## Requirements
- R1: Rate codes 0, 1, 2 and 3 give a full SCL period of 128, 112, 96 and 80 clock cycles respectively.
- R2: Rate codes 4, 5 and 6 give a full SCL period of 480, 60 and 30 clock cycles respectively.
- R3: Rate code 7 gives a full SCL period of 48 × (256 − reload) cycles, where reload is the 8-bit `timer_reload` value.
- R4: With no stretching, SCL is released for floor(P/2) cycles of each period P and held low for the remaining cycles.
- R5: While `master_en` is low, `scl_out` is high one cycle later, no pulses are produced, and the rate code has no effect.
- R6: The high-half count starts only in the cycle where `scl_in` is sampled high. A slave holding SCL low for S extra cycles lengthens the released time to floor(P/2)+S cycles and leaves the low time unchanged.
- R7: `scl_rise` is high for exactly one cycle, the first cycle of the counted high half. `scl_fall` is high for exactly one cycle, the first cycle that `scl_out` is low. There is one pulse of each per period.
- R8: `rate_sel` and `timer_reload` are captured on each clock edge where `bus_idle` is high. While `bus_idle` is low, the period in use does not change.
- R9: During and right after reset, `scl_out` is high and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | High while the engine acts as bus master |
| bus_idle | input | 1 | High while no transfer is in progress; enables rate capture |
| rate_sel | input | 3 | Rate code 0 to 7 |
| timer_reload | input | 8 | Reload value used by rate code 7 |
| scl_in | input | 1 | Sampled level of the SCL wire |
| scl_out | output | 1 | 0 pulls SCL low, 1 releases it |
| scl_rise | output | 1 | One-cycle pulse at the start of the counted high half |
| scl_fall | output | 1 | One-cycle pulse when SCL is driven low |

## Verification
A table sweeps all eight rate codes, using three reload values for the variable code: the smallest, a middle value and the largest period. Measuring low and high times separately tells a wrong divisor apart from a wrong split between the halves. A directed run holds SCL low for extra cycles after release. It shows that only the high half grows, and that the rise pulse waits for the line. Further runs change the rate code with the bus busy and then idle, which separates the capture timing from the divider itself. Another run leaves master mode off while the code changes and checks that the line stays released.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam int RATE_CODE_W = 3;

endpackage

// File: rtl/scl_rate_select.sv
module scl_rate_select
  import scl_rate_pkg::*;
#(
  parameter int DIV0        = 128,
  parameter int DIV1        = 112,
  parameter int DIV2        = 96,
  parameter int DIV3        = 80,
  parameter int DIV4        = 480,
  parameter int DIV5        = 60,
  parameter int DIV6        = 30,
  parameter int TIMER_SCALE = 48,
  parameter int RELOAD_W    = 8,
  parameter int PW          = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_idle,
  input  logic [RATE_CODE_W-1:0] rate_sel,
  input  logic [RELOAD_W-1:0]    timer_reload,
  output logic [PW-1:0]          hi_len,
  output logic [PW-1:0]          lo_len
);

  localparam int NFIX = 7;
  localparam int FIXED [NFIX] = '{DIV0, DIV1, DIV2, DIV3, DIV4, DIV5, DIV6};

  logic [RATE_CODE_W-1:0] code_q;
  logic [RELOAD_W-1:0]    reload_q;
  logic [PW-1:0]          period;
  logic [PW-1:0]          fixed_per [NFIX];

  // Capture the rate settings only while the bus is idle (R8).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      reload_q <= '0;
    end else if (bus_idle) begin
      code_q   <= rate_sel;
      reload_q <= timer_reload;
    end
  end

  for (genvar g = 0; g < NFIX; g++) begin : g_fixed
    assign fixed_per[g] = PW'(FIXED[g]);
  end

  always_comb begin
    if (code_q == RATE_CODE_W'(NFIX))
      period = PW'(TIMER_SCALE) * (PW'(2 ** RELOAD_W) - PW'(reload_q));
    else
      period = fixed_per[code_q];
  end

  // The high half rounds down and the low half takes the remainder (R4).
  assign hi_len = period >> 1;
  assign lo_len = period - hi_len;

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> ($stable(code_q) && $stable(reload_q)));

  a_r8_capture_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> (code_q == $past(rate_sel)));

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_rate_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en,
  input  logic          scl_in,
  input  logic [PW-1:0] hi_len,
  input  logic [PW-1:0] lo_len,
  output logic          scl_out,
  output logic          scl_rise,
  output logic          scl_fall
);

  scl_phase_e   ph_q;
  logic [PW-1:0] cnt_q;
  logic         rise_q;
  logic         fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OFF;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!master_en) begin
        ph_q  <= PH_OFF;
        cnt_q <= '0;
      end else begin
        unique case (ph_q)
          PH_OFF: begin
            ph_q  <= PH_WAIT;
            cnt_q <= '0;
          end
          PH_LOW: begin
            if (cnt_q + PW'(1) >= lo_len) begin
              ph_q  <= PH_WAIT;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + PW'(1);
            end
          end
          PH_WAIT: begin
            // Line released; the high count starts only once it reads high (R6).
            if (scl_in) begin
              ph_q   <= PH_HIGH;
              cnt_q  <= PW'(1);
              rise_q <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt_q + PW'(1) >= hi_len) begin
              ph_q   <= PH_LOW;
              cnt_q  <= '0;
              fall_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + PW'(1);
            end
          end
          default: ph_q <= PH_OFF;
        endcase
      end
    end
  end

  assign scl_out  = (ph_q != PH_LOW);
  assign scl_rise = rise_q;
  assign scl_fall = fall_q;

  a_r5_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (scl_out && !scl_rise && !scl_fall));

  a_r6_rise_after_high_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_rise) |-> $past(scl_in));

  a_r7_fall_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> !scl_out);

  a_r7_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall);

  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise);

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({scl_rise, scl_fall}) <= 1);

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int DIV0        = 128,
  parameter int DIV1        = 112,
  parameter int DIV2        = 96,
  parameter int DIV3        = 80,
  parameter int DIV4        = 480,
  parameter int DIV5        = 60,
  parameter int DIV6        = 30,
  parameter int TIMER_SCALE = 48,
  parameter int RELOAD_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   master_en,
  input  logic                   bus_idle,
  input  logic [RATE_CODE_W-1:0] rate_sel,
  input  logic [RELOAD_W-1:0]    timer_reload,
  input  logic                   scl_in,
  output logic                   scl_out,
  output logic                   scl_rise,
  output logic                   scl_fall
);

  localparam int PER_BOUND = TIMER_SCALE * (2 ** RELOAD_W)
                           + DIV0 + DIV1 + DIV2 + DIV3 + DIV4 + DIV5 + DIV6;
  localparam int PW = $clog2(PER_BOUND + 1) + 1;

  logic [PW-1:0] hi_len;
  logic [PW-1:0] lo_len;

  scl_rate_select #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3),
    .DIV4(DIV4), .DIV5(DIV5), .DIV6(DIV6),
    .TIMER_SCALE(TIMER_SCALE), .RELOAD_W(RELOAD_W), .PW(PW)
  ) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_idle     (bus_idle),
    .rate_sel     (rate_sel),
    .timer_reload (timer_reload),
    .hi_len       (hi_len),
    .lo_len       (lo_len)
  );

  scl_phase_ctl #(.PW(PW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .scl_in    (scl_in),
    .hi_len    (hi_len),
    .lo_len    (lo_len),
    .scl_out   (scl_out),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  a_r9_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (scl_out && !scl_rise && !scl_fall));

endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0;
  logic       bus_idle = 1'b1;
  logic [2:0] rate_sel = 3'd0;
  logic [7:0] timer_reload = 8'd0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_out, scl_rise, scl_fall;

  int checks = 0;
  int fails  = 0;
  int stretch_len = 0;
  int hold_left = 0;
  logic prev_out = 1'b1;
  logic rise_in_hold = 1'b0;

  always #10 clk = ~clk;

  assign scl_in = scl_out & ~hold;

  scl_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .bus_idle(bus_idle),
    .rate_sel(rate_sel), .timer_reload(timer_reload), .scl_in(scl_in),
    .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  // Slave model: hold SCL low for stretch_len cycles after each release.
  always @(negedge clk) begin
    if (hold && scl_rise) rise_in_hold <= 1'b1;
    if (hold_left > 0) begin
      hold_left <= hold_left - 1;
      if (hold_left == 1) hold <= 1'b0;
    end else if (scl_out && !prev_out && stretch_len > 0) begin
      hold      <= 1'b1;
      hold_left <= stretch_len;
    end
    prev_out <= scl_out;
  end

  // code, reload, expected period
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{0, 0, 128}, '{1, 0, 112}, '{2, 0, 96},  '{3, 0, 80},
    '{4, 0, 480}, '{5, 0, 60},  '{6, 0, 30},
    '{7, 255, 48}, '{7, 250, 288}, '{7, 0, 12288}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one full period from a falling pulse to the next one.
  task automatic measure(output int lo, output int hi, output int rises);
    lo = 0; hi = 0; rises = 0;
    do @(negedge clk); while (!scl_fall);
    forever begin
      if (scl_out) hi++; else lo++;
      if (scl_rise) rises++;
      @(negedge clk);
      if (scl_fall) break;
    end
  endtask

  task automatic start_rate(input int code, input int reload);
    master_en = 1'b0; bus_idle = 1'b1;
    rate_sel = 3'(code); timer_reload = 8'(reload);
    repeat (3) @(negedge clk);
    master_en = 1'b1;
    @(negedge clk);
    bus_idle = 1'b0;
  endtask

  initial begin
    int lo, hi, rs, cnt_p, cnt_low;
    repeat (3) @(negedge clk);
    check("R9 scl_out in reset", int'(scl_out), 1);
    check("R9 pulses in reset", int'(scl_rise | scl_fall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 scl_out after reset", int'(scl_out), 1);

    for (int i = 0; i < NV; i++) begin
      start_rate(VEC[i][0], VEC[i][1]);
      measure(lo, hi, rs);
      if (VEC[i][0] < 4)      check($sformatf("R1 period code %0d", VEC[i][0]), lo + hi, VEC[i][2]);
      else if (VEC[i][0] < 7) check($sformatf("R2 period code %0d", VEC[i][0]), lo + hi, VEC[i][2]);
      else                    check($sformatf("R3 period reload %0d", VEC[i][1]), lo + hi, VEC[i][2]);
      check($sformatf("R4 high half row %0d", i), hi, VEC[i][2] / 2);
      check($sformatf("R7 rise pulses row %0d", i), rs, 1);
    end

    // Stretch: slave holds SCL low 7 extra cycles.
    start_rate(6, 0);
    stretch_len = 7;
    measure(lo, hi, rs);
    measure(lo, hi, rs);
    check("R6 stretched high", hi, 15 + 7);
    check("R6 low unchanged", lo, 15);
    check("R6 rise after release", int'(rise_in_hold), 0);
    check("R7 one rise under stretch", rs, 1);
    stretch_len = 0;
    repeat (10) @(negedge clk);

    // Rate change while busy waits for idle.
    start_rate(0, 0);
    rate_sel = 3'd6;
    measure(lo, hi, rs);
    check("R8 busy keeps period", lo + hi, 128);
    bus_idle = 1'b1;
    measure(lo, hi, rs);
    measure(lo, hi, rs);
    check("R8 idle applies period", lo + hi, 30);

    // Master mode off: released line and no pulses whatever the code.
    master_en = 1'b0;
    @(negedge clk);
    check("R5 released one cycle after off", int'(scl_out), 1);
    cnt_p = 0; cnt_low = 0;
    for (int k = 0; k < 600; k++) begin
      rate_sel = 3'(k % 8);
      @(negedge clk);
      if (scl_rise || scl_fall) cnt_p++;
      if (!scl_out) cnt_low++;
    end
    check("R5 no pulses when off", cnt_p, 0);
    check("R5 no low when off", cnt_low, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule